// File: doc/BRIEF.md
# Two-Word Histogram Block Receiver

This block sits at the input of a histogramming memory and takes a 16-bit word stream from a shared front-end bus. Every event reaches it as a pair of words. The first word, the header, has its top bit set. The second word, the follower, has its top bit clear. The receiver joins the pair into one request for a histogram increment. Each request carries a 22-bit bin address and five pass-through flag bits, and it goes to the memory controller over a valid/ready handshake.

The header also holds a 3-bit module number. Up to eight memories can share one bus. Only a memory whose strap value matches that number turns the pair into a request. While a pair is half received, the receiver asserts a hold line so that the bus arbiter keeps its grant and no other sender can split the pair. Sequencing faults pulse an error strobe. An enable input from the readout side lets the receiver keep consuming words while it drops every completed pair.

Top module: `hist_block_rx`

## Requirements
- R1: After reset, `req_valid`, `hold_bus` and `seq_err` are 0, `in_ready` is 1, and the receiver holds no half-received pair.
- R2: An accepted word (`in_valid` and `in_ready` high at a clock edge) is a header when bit 15 is 1 and a follower when bit 15 is 0.
- R3: The header supplies the fields as bits [14:12] = module number, [11:7] = flags and [6:0] = address bits 21..15. The follower supplies address bits 14..0 in bits [14:0]. A request built from a pair appears on `req_addr`/`req_flags` with `req_valid` high in the cycle after the follower is accepted.
- R4: A completed pair raises `req_valid` only when its module number equals `strap_id`. Otherwise the pair is dropped and `req_valid` stays 0.
- R5: `hold_bus` is 1 from the cycle after a header is accepted until the cycle after the matching follower is accepted.
- R6: A follower accepted with no header pending is discarded. `seq_err` is 1 for the following cycle and no request is made.
- R7: A header accepted while another header is pending replaces the pending one. `seq_err` is 1 for the following cycle and `hold_bus` stays 1.
- R8: `in_ready` is 0 while `req_valid` is 1. A word offered during that time is not accepted and changes no state.
- R9: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr` and `req_flags` hold their values. The request clears in the cycle after `req_ready` is seen high.
- R10: When `rx_enable` is 0 at the edge where a follower completes a pair, the pair is consumed but no request is made. Header and follower sequencing, `hold_bus` and `seq_err` work the same as when `rx_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 16 | Word from the front-end bus |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | Receiver can take a word this cycle |
| rx_enable | input | 1 | When 0, completed pairs are dropped |
| strap_id | input | 3 | Local module number |
| hold_bus | output | 1 | Keep the bus grant; a pair is half received |
| seq_err | output | 1 | One-cycle sequencing error strobe |
| req_valid | output | 1 | Increment request pending |
| req_ready | input | 1 | Memory controller accepts the request |
| req_addr | output | 22 | Histogram bin address |
| req_flags | output | 5 | Spare flag bits from the header |

## Verification
The hardest case to reach from the ports is an input word offered while a request is stalled, because it needs a completed matching pair and a held-off `req_ready` at once. The stimulus gets there by lowering `req_ready`, sending a full pair and then offering a header for several cycles. It then checks that the header is not taken and that the request does not move. A behavioural model in the bench tracks the pending header and the pending request and is compared on every cycle. Error cases are built by sending followers with no header and headers back to back, with and without the enable set.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  parameter int WORD_W = 16;
  parameter int MOD_W  = 3;
  parameter int FLAG_W = 5;
  localparam int LO_W   = WORD_W - 1;
  localparam int HI_W   = WORD_W - 1 - MOD_W - FLAG_W;
  localparam int ADDR_W = HI_W + LO_W;

  typedef struct packed {
    logic [MOD_W-1:0]  mod;
    logic [FLAG_W-1:0] flags;
    logic [HI_W-1:0]   addr_hi;
  } hdr_t;

  function automatic logic is_header(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction

  function automatic hdr_t unpack_header(input logic [WORD_W-1:0] w);
    return hdr_t'(w[WORD_W-2:0]);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [HI_W-1:0] hi,
                                                  input logic [WORD_W-1:0] fol);
    return {hi, fol[LO_W-1:0]};
  endfunction
endpackage

// File: rtl/hbr_classify.sv
module hbr_classify
  import hbr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              take,
  output logic              hdr_fire,
  output logic              fol_fire,
  output hdr_t              hdr_fields
);
  always_comb begin
    hdr_fire   = take && is_header(word);
    fol_fire   = take && !is_header(word);
    hdr_fields = unpack_header(word);
  end
endmodule

// File: rtl/hbr_assembler.sv
module hbr_assembler
  import hbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_fire,
  input  logic              fol_fire,
  input  hdr_t              hdr_in,
  input  logic [WORD_W-1:0] fol_word,
  output logic              pending,
  output hdr_t              held_hdr,
  output logic              blk_done,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              err_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      held_hdr <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= (hdr_fire && pending) || (fol_fire && !pending);
      if (hdr_fire) begin
        pending  <= 1'b1;
        held_hdr <= hdr_in;
      end else if (fol_fire) begin
        pending <= 1'b0;
      end
    end
  end

  always_comb begin
    blk_done = fol_fire && pending;
    blk_addr = join_addr(held_hdr.addr_hi, fol_word);
  end
endmodule

// File: rtl/hbr_req_reg.sv
module hbr_req_reg
  import hbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [FLAG_W-1:0] push_flags,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [FLAG_W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      flags <= '0;
    end else if (push) begin
      valid <= 1'b1;
      addr  <= push_addr;
      flags <= push_flags;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hist_block_rx.sv
module hist_block_rx
  import hbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              rx_enable,
  input  logic [MOD_W-1:0]  strap_id,
  output logic              hold_bus,
  output logic              seq_err,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [FLAG_W-1:0] req_flags
);
  logic              word_take;
  logic              hdr_fire;
  logic              fol_fire;
  hdr_t              hdr_fields;
  hdr_t              held_hdr;
  logic              pending;
  logic              blk_done;
  logic [ADDR_W-1:0] blk_addr;
  logic              id_match;
  logic              req_push;
  logic [MOD_W-1:0]  held_module;

  assign in_ready    = !req_valid;
  assign word_take   = in_valid && in_ready;
  assign held_module = held_hdr.mod;
  assign id_match    = (held_module == strap_id);
  assign req_push    = blk_done && id_match && rx_enable;
  assign hold_bus    = pending;

  hbr_classify u_classify (
    .word       (in_word),
    .take       (word_take),
    .hdr_fire   (hdr_fire),
    .fol_fire   (fol_fire),
    .hdr_fields (hdr_fields)
  );

  hbr_assembler u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_fire (hdr_fire),
    .fol_fire (fol_fire),
    .hdr_in   (hdr_fields),
    .fol_word (in_word),
    .pending  (pending),
    .held_hdr (held_hdr),
    .blk_done (blk_done),
    .blk_addr (blk_addr),
    .err_q    (seq_err)
  );

  hbr_req_reg u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (req_push),
    .push_addr  (blk_addr),
    .push_flags (held_hdr.flags),
    .ready      (req_ready),
    .valid      (req_valid),
    .addr       (req_addr),
    .flags      (req_flags)
  );
endmodule

// File: rtl/hbr_checker.sv
module hbr_checker
  import hbr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] in_word,
  input logic              in_valid,
  input logic              in_ready,
  input logic              rx_enable,
  input logic [MOD_W-1:0]  strap_id,
  input logic              hold_bus,
  input logic              seq_err,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [FLAG_W-1:0] req_flags,
  input logic [MOD_W-1:0]  held_module
);
  logic take_hdr, take_fol;
  assign take_hdr = in_valid && in_ready && in_word[WORD_W-1];
  assign take_fol = in_valid && in_ready && !in_word[WORD_W-1];

  p_hold_after_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_hdr |=> hold_bus);
  p_release_after_fol_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_fol |=> !hold_bus);
  p_orphan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fol && !hold_bus) |=> (seq_err && !req_valid));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hdr && hold_bus) |=> (seq_err && hold_bus));
  p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fol && hold_bus && rx_enable && held_module == strap_id) |=> req_valid);
  p_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fol && hold_bus && held_module != strap_id) |=> !req_valid);
  p_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_flags)));
  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fol && !rx_enable) |=> !req_valid);
  p_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_valid) |=> $stable(hold_bus));
endmodule

bind hist_block_rx hbr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_word     (in_word),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .rx_enable   (rx_enable),
  .strap_id    (strap_id),
  .hold_bus    (hold_bus),
  .seq_err     (seq_err),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_flags   (req_flags),
  .held_module (held_module)
);

// File: tb/hist_block_rx_bench.sv
module hist_block_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        rx_enable = 1'b1;
  logic [2:0]  strap_id = 3'd5;
  logic        hold_bus, seq_err, req_valid;
  logic        req_ready = 1'b1;
  logic [21:0] req_addr;
  logic [4:0]  req_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hist_block_rx u_hist_block_rx (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .rx_enable(rx_enable), .strap_id(strap_id),
    .hold_bus(hold_bus), .seq_err(seq_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_flags(req_flags)
  );

  // behavioural reference
  bit          m_have, m_valid, m_err;
  bit [15:0]   m_hdr;
  bit [21:0]   m_addr;
  bit [4:0]    m_flags;
  int          m_reqs = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_have = 0; m_valid = 0; m_err = 0; m_hdr = 0; m_addr = 0; m_flags = 0;
    end else begin
      bit take;
      take = in_valid && !m_valid;
      m_err = 0;
      if (m_valid && req_ready) m_valid = 0;
      if (take) begin
        if (in_word[15]) begin
          if (m_have) m_err = 1;
          m_have = 1;
          m_hdr  = in_word;
        end else if (!m_have) begin
          m_err = 1;
        end else begin
          m_have = 0;
          if (rx_enable && (m_hdr >> 12) % 8 == strap_id) begin
            m_valid = 1;
            m_addr  = (22'((m_hdr % 128)) << 15) + 22'(in_word % 32768);
            m_flags = 5'((m_hdr >> 7) % 32);
            m_reqs++;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R8 in_ready", in_ready, !m_valid);
    chk("R5 hold_bus", hold_bus, m_have);
    chk("R6/R7 seq_err", seq_err, m_err);
    chk("R4 req_valid", req_valid, m_valid);
    if (m_valid) begin
      chk("R3 req_addr", req_addr, m_addr);
      chk("R3 req_flags", req_flags, m_flags);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic send(input logic [15:0] w);
    bit rdy;
    in_word  = w;
    in_valid = 1'b1;
    do begin
      rdy = in_ready;
      step();
    end while (!rdy);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] hdr(input int m, input int f, input int hi);
    return 16'h8000 | 16'((m % 8) << 12) | 16'((f % 32) << 7) | 16'(hi % 128);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 req_valid", req_valid, 0);
    chk("R1 hold_bus", hold_bus, 0);
    chk("R1 seq_err", seq_err, 0);
    chk("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    step();

    // R2 header classification, R3 fields, R4 match
    send(hdr(5, 5'h13, 7'h55));
    chk("R2 header holds bus", hold_bus, 1);
    send(16'h2A5A);
    chk("R3 addr", req_addr, {7'h55, 15'h2A5A});
    chk("R3 flags", req_flags, 5'h13);
    step(); step();

    // R4 mismatch
    send(hdr(2, 1, 1));
    send(16'h0001);
    chk("R4 mismatch no req", req_valid, 0);
    step();

    // R6 orphan follower
    send(16'h1234);
    chk("R6 orphan err", seq_err, 1);
    chk("R6 orphan no req", req_valid, 0);
    step();

    // R7 double header then follower uses second
    send(hdr(5, 2, 3));
    send(hdr(5, 9, 7'h7F));
    chk("R7 restart err", seq_err, 1);
    chk("R7 still holding", hold_bus, 1);
    send(16'h7FFF);
    chk("R7 second header used", req_addr, 22'h3FFFFF);
    step();

    // R9/R8 stall
    req_ready = 1'b0;
    send(hdr(5, 4, 9));
    send(16'h0100);
    in_word = hdr(5, 6, 6); in_valid = 1'b1;
    repeat (3) step();
    chk("R8 stalled header not taken", hold_bus, 0);
    chk("R9 held valid", req_valid, 1);
    chk("R9 held addr", req_addr, {7'd9, 15'h0100});
    req_ready = 1'b1;
    step();
    chk("R9 cleared after ready", req_valid, 0);
    step();
    chk("R8 header taken after stall", hold_bus, 1);
    in_valid = 1'b0;
    send(16'h0002);
    step();

    // R10 disabled: pair consumed, errors still tracked
    rx_enable = 1'b0;
    send(hdr(5, 1, 1));
    send(16'h0003);
    chk("R10 dropped", req_valid, 0);
    chk("R10 pair consumed", hold_bus, 0);
    send(16'h0004);
    chk("R10 orphan err", seq_err, 1);
    rx_enable = 1'b1;
    step();

    // gaps between words and strap change
    strap_id = 3'd0;
    in_word = hdr(0, 31, 0); in_valid = 1'b1; step();
    in_valid = 1'b0;
    repeat (4) step();
    chk("R5 hold during gap", hold_bus, 1);
    send(16'h0000);
    chk("R3 zero addr", req_addr, 0);
    chk("R3 full flags", req_flags, 5'h1F);

    // pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      req_ready = ((i * 7) % 5) != 0;
      rx_enable = (i % 37) != 0;
      in_valid  = ((i * 3) % 4) != 0;
      in_word   = 16'((i * 40503 + 12345) % 65536);
      step();
    end
    in_valid = 1'b0; req_ready = 1'b1;
    repeat (3) step();
    chk("R4 requests seen", m_reqs > 3, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule